// File: doc/BRIEF.md
# Cache Line Burst Bus Sequencer

This block stands between a cache and a pipelined, AHB-style system bus. It carries two kinds of traffic. The first is single uncached reads and writes, each of which takes one address phase and then one data phase. The second is whole cache-line fetches and writebacks, each of which runs as a counted burst of bus-width beats. One state machine covers both kinds. A beat counter tracks the data beat that is on the bus, and the transfer-type, burst-type and direction controls are decoded from the current state, the live requests and the bus ready signal.

The requester holds its uncached request until the stall output falls. The cache holds its line request until the line acknowledge pulses. A flush that arrives while nothing has been issued yet removes the request from the bus. A flush during a read data phase stops the returned word from being captured. A transfer that is already on the bus always runs to completion.

Top module: `linebus_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle with no request, htrans is IDLE (2'b00), beat is 0, and stall, line_ack and capture_en are all 0.
- R2: An uncached request (unc_req bit 1 = read, bit 0 = write) in the idle state without flush drives htrans NONSEQ (2'b10), hburst SINGLE (3'b000), hwrite equal to unc_req bit 0, and stall 1. If hready is high, the next cycle is a data phase with htrans IDLE.
- R3: While hready is low and a request is pending in the idle/address state, the block stays in that state and keeps driving NONSEQ with stall high.
- R4: capture_en is high only in a data phase whose request is a read, with hready high and flush low.
- R5: A flush in the idle/address state cancels the pending request. In that cycle htrans is IDLE and stall is 0, and no data phase follows.
- R6: A line fetch (line_req bit 1) issues NONSEQ with the burst code. It then runs BEATS = LINE_BITS/BUS_BITS data beats numbered 0 to BEATS-1, each advanced by hready. htrans is SEQ (2'b11) on every beat except the last, where it is IDLE.
- R7: When hready is low during a line transfer, beat holds its value.
- R8: line_ack pulses for exactly one cycle, when the final beat (beat = BEATS-1) completes with hready high. The block is idle again on the next cycle.
- R9: A writeback (line_req = 2'b01) runs the same beat sequence as a fetch, with hwrite 1 in its address phase and on all of its beats.
- R10: During line traffic hburst is 3'b011 for 4 beats, 3'b101 for 8 beats, 3'b111 for 16 beats and 3'b001 (INCR) otherwise. Uncached traffic uses 3'b000.
- R11: A flush during a line transfer or a data phase does not stop the transfer. The beats continue and the block returns to idle as usual.
- R12: When uncached and line requests are present together, the uncached request is issued first. Within line requests, a fetch has priority over a writeback.
- R13: stall is high while a transfer is pending or under way. It drops in the cycle a data phase completes (hready high) and in the cycle line_ack pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unc_req | input | 2 | Uncached request: bit 1 read, bit 0 write |
| line_req | input | 2 | Line request: bit 1 fetch, bit 0 writeback |
| hready | input | 1 | Bus ready, completes the current phase |
| flush | input | 1 | Cancel/discard request from the pipeline |
| htrans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| hburst | output | 3 | Burst type code |
| hwrite | output | 1 | Transfer direction, 1 = write |
| beat | output | CNTW | Index of the line data beat on the bus |
| capture_en | output | 1 | Capture the uncached read data this cycle |
| line_ack | output | 1 | Final line beat done, one-cycle pulse |
| stall | output | 1 | Requester must hold its request |

## Verification
Every output is a combinational decode of the registered state, the beat counter and the current inputs. A result is therefore due in the same cycle as the stimulus that causes it, and the state change that stimulus causes appears one clock edge later. The bench drives inputs 1 ns after a rising edge and samples 3 ns after it, before the next edge. Each table row thus checks the cycle its own inputs produce, and the following row observes the state transition. Holds under low hready, flush cancellation and the return to idle after line_ack are each checked on the cycle after the event, through htrans, beat and stall.

// File: rtl/linebus_pkg.sv
package linebus_pkg;

  typedef enum logic [1:0] {
    ST_ADDR  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FETCH = 2'd2,
    ST_WBACK = 2'd3
  } lb_state_e;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;

  // Beats in one line transfer
  function automatic int beats_per_line(input int line_bits, input int bus_bits);
    return line_bits / bus_bits;
  endfunction

  // Burst code for a given beat count (R10)
  function automatic logic [2:0] burst_code(input int beats);
    case (beats)
      4:       return 3'b011;
      8:       return 3'b101;
      16:      return 3'b111;
      default: return HB_INCR;
    endcase
  endfunction

endpackage

// File: rtl/linebus_beat_ctr.sv
module linebus_beat_ctr #(
  parameter int BEATS = 4,
  parameter int CNTW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [CNTW-1:0] beat,
  output logic            last
);

  localparam logic [CNTW-1:0] LAST_IDX = CNTW'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   beat <= '0;
    else if (clr) beat <= '0;
    else if (adv) beat <= beat + 1'b1;
  end

  assign last = (beat == LAST_IDX);

endmodule

// File: rtl/linebus_seq.sv
module linebus_seq
  import linebus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] unc_req,
  input  logic [1:0] line_req,
  input  logic      hready,
  input  logic      flush,
  input  logic      last,
  output lb_state_e state,
  output lb_state_e next_state
);

  always_comb begin
    next_state = state;
    case (state)
      ST_ADDR: begin
        if (!flush && hready) begin
          if (|unc_req)         next_state = ST_DATA;   // uncached first (R12)
          else if (line_req[1]) next_state = ST_FETCH;
          else if (line_req[0]) next_state = ST_WBACK;
        end
      end
      ST_DATA:  if (hready) next_state = ST_ADDR;
      ST_FETCH,
      ST_WBACK: if (hready && last) next_state = ST_ADDR;
      default:  next_state = ST_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_ADDR;
    else        state <= next_state;
  end

endmodule

// File: rtl/linebus_bus_drv.sv
module linebus_bus_drv
  import linebus_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  lb_state_e  state,
  input  logic [1:0] unc_req,
  input  logic [1:0] line_req,
  input  logic       hready,
  input  logic       flush,
  input  logic       last,
  output logic [1:0] htrans,
  output logic [2:0] hburst,
  output logic       hwrite,
  output logic       capture_en,
  output logic       line_ack,
  output logic       stall
);

  localparam logic [2:0] LINE_BURST = burst_code(BEATS);

  logic any_unc, any_line, issue;
  assign any_unc  = |unc_req;
  assign any_line = |line_req;
  assign issue    = !flush && (any_unc || any_line);

  always_comb begin
    htrans     = HT_IDLE;
    hburst     = HB_SINGLE;
    hwrite     = 1'b0;
    capture_en = 1'b0;
    line_ack   = 1'b0;
    stall      = 1'b0;
    case (state)
      ST_ADDR: begin
        if (issue) begin
          htrans = HT_NONSEQ;
          stall  = 1'b1;
          if (any_unc) begin
            hwrite = unc_req[0];
          end else begin
            hburst = LINE_BURST;
            hwrite = !line_req[1] && line_req[0];
          end
        end
      end
      ST_DATA: begin
        capture_en = unc_req[1] && hready && !flush;
        stall      = !hready;
      end
      ST_FETCH,
      ST_WBACK: begin
        htrans   = last ? HT_IDLE : HT_SEQ;
        hburst   = LINE_BURST;
        hwrite   = (state == ST_WBACK);
        line_ack = last && hready;
        stall    = !(last && hready);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/linebus_ctrl.sv
module linebus_ctrl
  import linebus_pkg::*;
#(
  parameter int LINE_BITS = 256,
  parameter int BUS_BITS  = 64,
  localparam int BEATS    = beats_per_line(LINE_BITS, BUS_BITS),
  localparam int CNTW     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      unc_req,
  input  logic [1:0]      line_req,
  input  logic            hready,
  input  logic            flush,
  output logic [1:0]      htrans,
  output logic [2:0]      hburst,
  output logic            hwrite,
  output logic [CNTW-1:0] beat,
  output logic            capture_en,
  output logic            line_ack,
  output logic            stall
);

  lb_state_e state, next_state;
  logic      last;

  // Named events for the checks below
  logic in_adr, in_data, in_cache, req_any, cnt_clr, cnt_adv;
  assign in_adr   = (state == ST_ADDR);
  assign in_data  = (state == ST_DATA);
  assign in_cache = (state == ST_FETCH) || (state == ST_WBACK);
  assign req_any  = (|unc_req) || (|line_req);
  assign cnt_clr  = (next_state == ST_ADDR);
  assign cnt_adv  = in_cache && hready;

  linebus_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .unc_req    (unc_req),
    .line_req   (line_req),
    .hready     (hready),
    .flush      (flush),
    .last       (last),
    .state      (state),
    .next_state (next_state)
  );

  linebus_beat_ctr #(.BEATS(BEATS), .CNTW(CNTW)) i_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .adv   (cnt_adv),
    .beat  (beat),
    .last  (last)
  );

  linebus_bus_drv #(.BEATS(BEATS)) i_drv (
    .state      (state),
    .unc_req    (unc_req),
    .line_req   (line_req),
    .hready     (hready),
    .flush      (flush),
    .last       (last),
    .htrans     (htrans),
    .hburst     (hburst),
    .hwrite     (hwrite),
    .capture_en (capture_en),
    .line_ack   (line_ack),
    .stall      (stall)
  );

  a_r1_idle_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_adr |-> (beat == '0));

  a_r2_data_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adr && (|unc_req) && !flush && hready) |=> in_data);

  a_r3_adr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adr && req_any && !hready) |=> in_adr);

  a_r4_capture_qual: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> (in_data && !flush && hready));

  a_r5_flush_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adr && flush) |=> in_adr);

  a_r6_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cache && hready && !line_ack) |=> (beat == CNTW'($past(beat) + 1'b1)));

  a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cache && !hready) |=> $stable(beat));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_ack |=> (in_adr && !line_ack));

endmodule

// File: tb/test_linebus_ctrl.sv
module test_linebus_ctrl;

  localparam int LINE_BITS = 256;
  localparam int BUS_BITS  = 64;
  localparam int NB        = LINE_BITS / BUS_BITS;
  localparam int CW        = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    unc_req = '0, line_req = '0;
  logic          hready = 1'b0, flush = 1'b0;
  logic [1:0]    htrans;
  logic [2:0]    hburst;
  logic          hwrite, capture_en, line_ack, stall;
  logic [CW-1:0] beat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  linebus_ctrl #(.LINE_BITS(LINE_BITS), .BUS_BITS(BUS_BITS)) i_linebus_ctrl (
    .clk(clk), .rst_n(rst_n), .unc_req(unc_req), .line_req(line_req),
    .hready(hready), .flush(flush), .htrans(htrans), .hburst(hburst),
    .hwrite(hwrite), .beat(beat), .capture_en(capture_en),
    .line_ack(line_ack), .stall(stall)
  );

  // Expected burst code, written independently of the design
  function automatic logic [2:0] exp_burst(input int n);
    if (n == 4)  return 3'b011;
    if (n == 8)  return 3'b101;
    if (n == 16) return 3'b111;
    return 3'b001;
  endfunction

  // Row: {req id, unc, line, rdy, flush, htrans, beat, cap, ack, stall, hwrite}
  localparam int NV = 19;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {4'd1,  2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 idle
    {4'd3,  2'b10, 2'b00, 1'b0, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 wait
    {4'd2,  2'b10, 2'b00, 1'b1, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 read issue
    {4'd4,  2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 data wait
    {4'd4,  2'b10, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 capture
    {4'd2,  2'b01, 2'b00, 1'b1, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 write issue
    {4'd4,  2'b01, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 no cap on write
    {4'd6,  2'b00, 2'b10, 1'b1, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 fetch issue
    {4'd6,  2'b00, 2'b10, 1'b1, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 beat0
    {4'd7,  2'b00, 2'b10, 1'b0, 1'b0, 2'b11, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 beat1 wait
    {4'd7,  2'b00, 2'b10, 1'b1, 1'b0, 2'b11, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 beat1 held
    {4'd11, 2'b00, 2'b10, 1'b1, 1'b1, 2'b11, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 flush ignored
    {4'd8,  2'b00, 2'b10, 1'b1, 1'b0, 2'b00, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 final ack
    {4'd9,  2'b00, 2'b01, 1'b1, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 wb issue
    {4'd9,  2'b00, 2'b01, 1'b1, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 beat0
    {4'd9,  2'b00, 2'b01, 1'b1, 1'b0, 2'b11, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 beat1
    {4'd13, 2'b00, 2'b01, 1'b1, 1'b0, 2'b11, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1}, // R13 beat2
    {4'd8,  2'b00, 2'b01, 1'b1, 1'b0, 2'b00, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 wb ack
    {4'd8,  2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 idle after ack
  };

  task automatic drive(input logic [1:0] u, input logic [1:0] l, input logic r, input logic f);
    @(posedge clk);
    #1;
    unc_req = u; line_req = l; hready = r; flush = f;
    #2;
  endtask

  // Compare {htrans, beat, cap, ack, stall, hwrite}
  task automatic check(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {htrans, beat, capture_en, line_ack, stall, hwrite};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {htrans,beat,cap,ack,stall,hwrite} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_burst(input string tag, input logic [2:0] exp);
    n_tests++;
    if (hburst !== exp) begin
      n_fail++;
      $display("FAIL %s: hburst actual=%b expected=%b", tag, hburst, exp);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #3;
    check("R1 in reset", 8'b00_00_0000);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:12], VEC[i][11:10], VEC[i][9], VEC[i][8]);
      check($sformatf("R%0d table row %0d", VEC[i][17:14], i), VEC[i][7:0]);
    end

    // R5: flush cancels pending uncached read in address state
    drive(2'b10, 2'b00, 1'b1, 1'b1);
    check("R5 flush cancels issue", 8'b00_00_0000);
    drive(2'b10, 2'b00, 1'b1, 1'b0);
    check("R5 still in address state", 8'b10_00_0010);
    // R11: flush in data phase blocks capture, phase still completes
    drive(2'b10, 2'b00, 1'b1, 1'b1);
    check("R11 data phase flush no capture", 8'b00_00_0000);
    drive(2'b00, 2'b00, 1'b1, 1'b0);
    check("R11 back to idle", 8'b00_00_0000);

    // R12: uncached wins over line fetch
    drive(2'b10, 2'b10, 1'b1, 1'b0);
    check_burst("R12 uncached single burst", 3'b000);
    drive(2'b10, 2'b10, 1'b1, 1'b0);
    check("R12 data phase taken first", 8'b00_00_1000);

    // R12 + R10: fetch over writeback, line burst code
    drive(2'b00, 2'b11, 1'b0, 1'b0);
    check("R12 fetch preferred, not write", 8'b10_00_0010);
    check_burst("R10 line burst in address", exp_burst(NB));
    drive(2'b00, 2'b11, 1'b1, 1'b0);
    drive(2'b00, 2'b11, 1'b1, 1'b0);
    check_burst("R10 line burst on beats", exp_burst(NB));
    check("R6 fetch beat0 SEQ", 8'b11_00_0010);
    for (int b = 1; b < NB; b++) drive(2'b00, 2'b11, 1'b1, 1'b0);
    check("R8 final beat ack", 8'b00_11_0100);
    drive(2'b00, 2'b00, 1'b0, 1'b0);
    check("R8 ack is one cycle, idle", 8'b00_00_0000);

    // R13: stall tracks uncached write while bus waits
    drive(2'b01, 2'b00, 1'b1, 1'b0);
    drive(2'b01, 2'b00, 1'b0, 1'b0);
    check("R13 stall during data wait", 8'b00_00_0010);
    drive(2'b01, 2'b00, 1'b1, 1'b0);
    check("R13 stall drops at completion", 8'b00_00_0000);
    check_burst("R10 uncached single", 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule